// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block checks whether an external monitored clock runs near its expected rate. In the reference clock domain it counts prescaled reference ticks over a fixed block of monitored-clock periods. At the end of each block it keeps the count and tests it against a programmable acceptance window. A count outside the window sets an error level, sets a sticky error bit and fires a one-cycle interrupt. The error can also drive a mute request for the downstream data path.

The monitored clock passes through a two-stage synchronizer, and an edge detector finds its rising edges. A power-of-two prescaler scales the reference clock, so a slow monitored clock still gives a count that fits the 8-bit counter. Measurements follow each other with no gap. Deasserting the enable returns all measurement state to idle.

Top module: `clk_freq_monitor`

## Requirements
- R1: One measurement covers 32 consecutive rising-edge-to-rising-edge periods of the monitored clock. If that clock has a period of P reference cycles and the prescaler divides by D, with D dividing 32·P, the count is 32·P/D. The count appears on `count_o` and stays there until the next measurement completes.
- R2: `psel_i` values 0 through 8 select a divide ratio of 2^psel_i. Any value from 9 to 15 divides by 256.
- R3: The count saturates at 255 and does not wrap.
- R4: After each completed measurement, `err_o` is 1 if the count is greater than `max_i` or less than `min_i`, and 0 otherwise. Both bounds are inclusive, so a count equal to a bound is accepted.
- R5: `irq_o` is high for exactly one reference cycle for each completed measurement that fails the window test. It never rises for a measurement that passes.
- R6: `err_sticky_o` is set by every failing measurement. It stays set through later passing measurements and is cleared only when `clr_sticky_i` is high for a cycle. If a failure and a clear fall in the same cycle, the set wins.
- R7: `mute_o` equals `err_o` while `mute_en_i` is 1. It is 0 while `mute_en_i` is 0.
- R8: While `en_i` is 0, no measurement completes, `irq_o` stays 0, and `err_o` and `mute_o` are 0 from the next cycle on. `count_o` keeps its last value.
- R9: After `en_i` rises, no measurement completes before 32 full monitored-clock periods have elapsed.
- R10: After reset, `count_o`, `err_o`, `err_sticky_o`, `irq_o` and `mute_o` are all 0.
- R11: The monitored clock may run as fast as one quarter of the reference clock rate, and R1 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mon_clk_i | input | 1 | Monitored clock, asynchronous to clk_i |
| en_i | input | 1 | Enables the check function |
| psel_i | input | 4 | Prescale select code |
| min_i | input | 8 | Lowest accepted count |
| max_i | input | 8 | Highest accepted count |
| mute_en_i | input | 1 | Lets an error drive the mute request |
| clr_sticky_i | input | 1 | Write-one-to-clear for the sticky error |
| count_o | output | 8 | Last captured count |
| err_o | output | 1 | Result of the most recent comparison |
| err_sticky_o | output | 1 | Sticky error flag |
| irq_o | output | 1 | One-cycle pulse per failing measurement |
| mute_o | output | 1 | Hardware mute request |

## Verification
A wrong period counter or a misplaced window boundary changes `count_o` at the first capture after enable, about 32 monitored periods later. A prescaler mask that is off by one bit shows the same way, as a count that is off by a factor of two. A lost saturation shows up as a small wrapped count together with a false error, and only in that same cycle. Faults in the status logic appear one cycle after capture, as an `irq_o` that lasts too long, a sticky bit that clears itself, or a mute request that ignores its enable.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    localparam int unsigned CNT_W_DEF     = 8;
    localparam int unsigned PERIODS_DEF   = 32;
    localparam int unsigned PSEL_W_DEF    = 4;
    localparam int unsigned MAX_SHIFT_DEF = 8;
    localparam int unsigned SYNC_DEF      = 2;

    typedef struct packed {
        logic [CNT_W_DEF-1:0] count;
        logic                 err;
        logic                 sticky;
        logic                 irq;
    } status_t;

endpackage

// File: rtl/clkmon_edge.sv
module clkmon_edge #(
    parameter int unsigned STAGES = clkmon_pkg::SYNC_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    // sh_q[0..STAGES-1] are synchronizer flops, sh_q[STAGES] is history
    typedef struct packed {
        logic [STAGES:0] sh;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[STAGES-1:0], async_i};
        rise_o = s_q.sh[STAGES-1] & ~s_q.sh[STAGES];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R11: a detected rise means the history flop was low beforehand
    a_r11_rise_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> s_q.sh[STAGES]);

endmodule

// File: rtl/clkmon_prescaler.sv
module clkmon_prescaler #(
    parameter int unsigned PSEL_W    = clkmon_pkg::PSEL_W_DEF,
    parameter int unsigned MAX_SHIFT = clkmon_pkg::MAX_SHIFT_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [PSEL_W-1:0] psel_i,
    output logic              tick_o
);
    localparam int unsigned DIV_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_state_t;

    pre_state_t       s_d, s_q;
    logic [DIV_W-1:0] mask;
    int unsigned      shift;

    always_comb begin
        shift = (int'(psel_i) > int'(MAX_SHIFT)) ? MAX_SHIFT : int'(psel_i);
    end

    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (i < shift);
    end

    always_comb begin
        s_d    = s_q;
        tick_o = en_i && (s_q.pre >= mask);
        if (!en_i) begin
            s_d.pre = '0;
        end else if (tick_o) begin
            s_d.pre = '0;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R8: the prescaler stays parked while disabled
    a_r8_pre_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (s_q.pre == '0));

endmodule

// File: rtl/clkmon_window.sv
module clkmon_window #(
    parameter int unsigned CNT_W   = clkmon_pkg::CNT_W_DEF,
    parameter int unsigned PERIODS = clkmon_pkg::PERIODS_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             rise_i,
    input  logic             tick_i,
    output logic             done_o,
    output logic [CNT_W-1:0] result_o
);
    localparam int unsigned PER_W   = (PERIODS > 1) ? $clog2(PERIODS) : 1;
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIODS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic             started;
        logic [PER_W-1:0] per;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t       s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_fresh;

    always_comb begin
        cnt_inc   = (s_q.cnt == CNT_MAX) ? CNT_MAX : s_q.cnt + 1'b1;
        cnt_fresh = tick_i ? CNT_W'(1) : '0;
    end

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        if (!en_i) begin
            s_d = '0;
        end else if (rise_i) begin
            if (!s_q.started) begin
                s_d.started = 1'b1;
                s_d.per     = '0;
                s_d.cnt     = cnt_fresh;
            end else if (s_q.per == PER_LAST) begin
                done_o  = 1'b1;
                s_d.per = '0;
                s_d.cnt = cnt_fresh;
            end else begin
                s_d.per = s_q.per + 1'b1;
                if (tick_i) s_d.cnt = cnt_inc;
            end
        end else if (s_q.started && tick_i) begin
            s_d.cnt = cnt_inc;
        end
        result_o = s_q.cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R3: a saturated count stays saturated until the window closes
    a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && s_q.started && s_q.cnt == CNT_MAX && !rise_i) |=> (s_q.cnt == CNT_MAX));

    // R9: nothing completes before a first edge has armed the window
    a_r9_armed_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> s_q.started);

    // R1: after a completed window the period count restarts
    a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (s_q.per == '0));

endmodule

// File: rtl/clk_freq_monitor.sv
module clk_freq_monitor #(
    parameter int unsigned CNT_W     = clkmon_pkg::CNT_W_DEF,
    parameter int unsigned PERIODS   = clkmon_pkg::PERIODS_DEF,
    parameter int unsigned PSEL_W    = clkmon_pkg::PSEL_W_DEF,
    parameter int unsigned MAX_SHIFT = clkmon_pkg::MAX_SHIFT_DEF,
    parameter int unsigned SYNC      = clkmon_pkg::SYNC_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mon_clk_i,
    input  logic              en_i,
    input  logic [PSEL_W-1:0] psel_i,
    input  logic [CNT_W-1:0]  min_i,
    input  logic [CNT_W-1:0]  max_i,
    input  logic              mute_en_i,
    input  logic              clr_sticky_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              err_o,
    output logic              err_sticky_o,
    output logic              irq_o,
    output logic              mute_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             err;
        logic             sticky;
        logic             irq;
    } top_state_t;

    logic             rise;
    logic             tick;
    logic             done;
    logic [CNT_W-1:0] result;
    logic             bad;

    top_state_t s_d, s_q;

    clkmon_edge #(.STAGES(SYNC)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(mon_clk_i),
        .rise_o (rise)
    );

    clkmon_prescaler #(.PSEL_W(PSEL_W), .MAX_SHIFT(MAX_SHIFT)) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .psel_i(psel_i),
        .tick_o(tick)
    );

    clkmon_window #(.CNT_W(CNT_W), .PERIODS(PERIODS)) u_win (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .rise_i  (rise),
        .tick_i  (tick),
        .done_o  (done),
        .result_o(result)
    );

    always_comb begin
        bad = (result > max_i) || (result < min_i);
        s_d = s_q;
        s_d.irq = 1'b0;
        if (!en_i) begin
            s_d.err = 1'b0;
        end
        if (clr_sticky_i) begin
            s_d.sticky = 1'b0;
        end
        if (done) begin
            s_d.count = result;
            s_d.err   = bad;
            s_d.irq   = bad;
            if (bad) s_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign count_o      = s_q.count;
    assign err_o        = s_q.err;
    assign err_sticky_o = s_q.sticky;
    assign irq_o        = s_q.irq;
    assign mute_o       = s_q.err & mute_en_i;

    // R5: the interrupt lasts a single reference cycle
    a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    // R4: an interrupt always comes with the error level
    a_r4_irq_has_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> err_o);

    // R6: a failure always leaves the sticky bit set
    a_r6_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> err_sticky_o);

    // R8: disabling silences the error and interrupt
    a_r8_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!irq_o && !err_o));

    // R8: the captured count is held while disabled
    a_r8_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(count_o));

endmodule

// File: tb/tb_clk_freq_monitor.sv
module tb_clk_freq_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon = 1'b0;
    logic       en = 1'b0;
    logic [3:0] psel = '0;
    logic [7:0] min_b = '0;
    logic [7:0] max_b = '0;
    logic       mute_en = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] count;
    logic       err, sticky, irq, mute;

    int checks = 0;
    int errors = 0;
    int half   = 4;
    int ph     = 0;
    int irq_cnt = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    clk_freq_monitor dut (
        .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mon), .en_i(en),
        .psel_i(psel), .min_i(min_b), .max_i(max_b), .mute_en_i(mute_en),
        .clr_sticky_i(clr), .count_o(count), .err_o(err),
        .err_sticky_o(sticky), .irq_o(irq), .mute_o(mute)
    );

    // monitored clock, period 2*half reference cycles
    always @(negedge clk) begin
        if (ph >= half - 1) begin
            mon <= ~mon;
            ph  <= 0;
        end else begin
            ph <= ph + 1;
        end
        if (irq) irq_cnt <= irq_cnt + 1;
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Disable, set up, enable; waits for one completed window
    task automatic run_win(input int p, input int ps, input int lo, input int hi,
                           input bit me, input int r9_hold);
        @(negedge clk);
        en = 1'b0;
        wait_cyc(4);
        half = p / 2;
        psel = 4'(ps);
        min_b = 8'(lo);
        max_b = 8'(hi);
        mute_en = me;
        wait_cyc(2 * p);
        irq_cnt = 0;
        en = 1'b1;
        if (r9_hold >= 0) begin
            wait_cyc(20 * p);
            check("R9 count held early", int'(count), r9_hold);
            check("R9 no irq early", irq_cnt, 0);
            wait_cyc(16 * p + 10);
        end else begin
            wait_cyc(36 * p + 10);
        end
    endtask

    task automatic t_reset;
        check("R10 count", int'(count), 0);
        check("R10 err", int'(err), 0);
        check("R10 sticky", int'(sticky), 0);
        check("R10 irq", int'(irq), 0);
        check("R10 mute", int'(mute), 0);
    endtask

    task automatic t_in_window_exact;
        // P=8, divide 2 -> 128; both bounds equal the count
        run_win(8, 1, 128, 128, 1'b1, -1);
        check("R1 R2 count div2", int'(count), 128);
        check("R4 bound inclusive err", int'(err), 0);
        check("R5 no irq on pass", irq_cnt, 0);
        check("R7 mute low when pass", int'(mute), 0);
    endtask

    task automatic t_below_min;
        // P=8, divide 4 -> 64 < 120
        run_win(8, 2, 120, 200, 1'b1, -1);
        check("R2 count div4", int'(count), 64);
        check("R4 below min err", int'(err), 1);
        check("R5 one irq per fail", irq_cnt, 1);
        check("R6 sticky set", int'(sticky), 1);
        check("R7 mute follows err", int'(mute), 1);
    endtask

    task automatic t_saturate;
        // P=8, divide 1 -> 256 saturates to 255; checks early hold of 64
        run_win(8, 0, 0, 200, 1'b0, 64);
        check("R3 saturate", int'(count), 255);
        check("R4 above max err", int'(err), 1);
        check("R7 mute gated off", int'(mute), 0);
        @(negedge clk);
        mute_en = 1'b1;
        #1;
        check("R7 mute enabled", int'(mute), 1);
    endtask

    task automatic t_div_clamp;
        // P=16, code 12 -> divide 256 -> 512/256 = 2
        run_win(16, 12, 0, 255, 1'b0, -1);
        check("R2 code above 8 clamps", int'(count), 2);
        check("R4 pass err low", int'(err), 0);
        check("R6 sticky survives pass", int'(sticky), 1);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R6 sticky cleared", int'(sticky), 0);
    endtask

    task automatic t_quarter;
        // P=4, divide 1 -> 128
        run_win(4, 0, 100, 150, 1'b0, -1);
        check("R11 quarter rate count", int'(count), 128);
        check("R11 quarter rate err", int'(err), 0);
    endtask

    task automatic t_disable;
        int held;
        // produce an error state first: P=8 divide 8 -> 32 < 100
        run_win(8, 3, 100, 200, 1'b1, -1);
        check("R2 count div8", int'(count), 32);
        check("R4 err before disable", int'(err), 1);
        held = int'(count);
        @(negedge clk);
        en = 1'b0;
        half = 6;
        irq_cnt = 0;
        @(negedge clk);
        check("R8 err cleared", int'(err), 0);
        check("R8 mute cleared", int'(mute), 0);
        wait_cyc(600);
        check("R8 no irq disabled", irq_cnt, 0);
        check("R8 count held", int'(count), held);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_in_window_exact();
        t_below_min();
        t_saturate();
        t_div_clamp();
        t_quarter();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule